// File: doc/BRIEF.md
# Glitch-Free Clock Output Gate Bank

This block takes one free-running reference clock and produces a bank of gated copies of it, four by default. Each copy is switched on and off by two conditions: an external enable pin that may change at any time with no relation to the reference clock, and an enable bit from a control register that is synchronous to the reference clock. A copy runs only while both conditions are true. Dropping either one stops it.

Stops and restarts are clean. A gate opens or closes only while the reference clock is low, so no output ever shows a clipped or lengthened high phase. A stopped output stays parked at logic low. Each output has its own gate, and switching one output leaves the others running without disturbance.

Each output also has a status flag that reports whether its gate is open. The flag changes on the same falling edge of the reference clock at which the gate opens or closes.

Top module: `refclk_gate_bank`

## Requirements
- R1: With the inputs held steady, an output toggles on every reference cycle only when both its enable pin and its register enable bit are 1.
- R2: If either the enable pin or the register enable bit of an output is 0, that output stays at 0 with no pulses.
- R3: When an output stops, its last high pulse lasts a full half period of the reference clock, and the output then remains at 0.
- R4: Every high pulse on every output lasts exactly half a reference period. Every low gap lasts half a period plus a whole number of periods.
- R5: Take an enable pin change applied just after rising reference edge E0, with the register bit already 1. The first output rise comes at rising edge E3, which is inside the allowed window of 2 to 6 output cycles. When the pin drops, the last output rise is at E2.
- R6: Take a register enable bit change applied just after rising edge E0, with the pin already high. The first output rise comes at E2. When the bit drops, the last output rise is at E1.
- R7: Starting or stopping one output does not remove, add or reshape any pulse on the other outputs.
- R8: The status flag of an output is 1 exactly while its gate is open. It changes only while the reference clock is low. During reset every flag and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_en | input | NUM_OUT | Asynchronous per-output enable pins, active high |
| reg_en | input | NUM_OUT | Register enable bits, synchronous to ref_clk, active high |
| clk_out | output | NUM_OUT | Gated clock outputs, parked low when stopped |
| running | output | NUM_OUT | Per-output flag, 1 while the gate is open |

## Verification
Suppose a gate register updated on the wrong clock edge, or the synchronizer had the wrong depth. The first would show a clipped or stretched pulse at the very next transition. The second would move the first or last output rise away from the expected rising edge, visible within six reference cycles of the enable change. A stuck or crossed enable would show as a wrong running flag and a wrong pulse count within one measurement window of eight cycles. Pulse widths and gaps are timed on every output across the whole run, so disturbance of a neighbouring output is caught as it happens.

// File: rtl/refclk_gate_pkg.sv
package refclk_gate_pkg;
   localparam int unsigned RCG_MIN_LATENCY = 2;
   localparam int unsigned RCG_MAX_LATENCY = 6;

   // Cycles from enable change (after rising edge E0) to first output rise.
   function automatic int unsigned pin_latency(input int unsigned stages);
      return stages + 1;
   endfunction

   function automatic int unsigned reg_latency(input bit retime);
      return retime ? 2 : 1;
   endfunction
endpackage

// File: rtl/rcg_neg_sync.sv
module rcg_neg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(negedge ref_clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rcg_gate_cell.sv
module rcg_gate_cell #(
   parameter bit REG_RETIME = 1'b1
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic pin_ok,
   input  logic reg_ok,
   output logic clk_o,
   output logic open_o
);
   logic reg_path;
   logic gate_q;

   generate
      if (REG_RETIME) begin : g_retime
         logic reg_q;
         always_ff @(negedge ref_clk or negedge rst_n) begin
            if (!rst_n) reg_q <= 1'b0;
            else        reg_q <= reg_ok;
         end
         assign reg_path = reg_q;
      end else begin : g_direct
         assign reg_path = reg_ok;
      end
   endgenerate

   // Gate flop moves only on the falling edge, i.e. while the clock is low.
   always_ff @(negedge ref_clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= pin_ok & reg_path;
   end

   assign clk_o  = ref_clk & gate_q;
   assign open_o = gate_q;
endmodule

// File: rtl/refclk_gate_bank.sv
module refclk_gate_bank
   import refclk_gate_pkg::*;
#(
   parameter int unsigned NUM_OUT     = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REG_RETIME  = 1'b1
) (
   input  logic               ref_clk,
   input  logic               rst_n,
   input  logic [NUM_OUT-1:0] pin_en,
   input  logic [NUM_OUT-1:0] reg_en,
   output logic [NUM_OUT-1:0] clk_out,
   output logic [NUM_OUT-1:0] running
);
   localparam int unsigned PIN_LAT = pin_latency(SYNC_STAGES);
   localparam int unsigned REG_LAT = reg_latency(REG_RETIME);

   generate
      if (NUM_OUT < 1) begin : g_bad_outs
         $error("refclk_gate_bank: NUM_OUT must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("refclk_gate_bank: SYNC_STAGES must be at least 2");
      end
      if (PIN_LAT > RCG_MAX_LATENCY || PIN_LAT < RCG_MIN_LATENCY) begin : g_bad_pin_lat
         $error("refclk_gate_bank: pin restart latency outside window");
      end
      if (REG_LAT < RCG_MIN_LATENCY) begin : g_bad_reg_lat
         $error("refclk_gate_bank: register restart latency below window");
      end

      for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
         logic pin_sync;

         rcg_neg_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .ref_clk (ref_clk),
            .rst_n   (rst_n),
            .d       (pin_en[g]),
            .q       (pin_sync)
         );

         rcg_gate_cell #(.REG_RETIME(REG_RETIME)) u_cell (
            .ref_clk (ref_clk),
            .rst_n   (rst_n),
            .pin_ok  (pin_sync),
            .reg_ok  (reg_en[g]),
            .clk_o   (clk_out[g]),
            .open_o  (running[g])
         );
      end
   endgenerate
endmodule

// File: rtl/refclk_gate_chk.sv
module refclk_gate_chk #(
   parameter int unsigned NUM_OUT     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic               ref_clk,
   input logic               rst_n,
   input logic [NUM_OUT-1:0] pin_en,
   input logic [NUM_OUT-1:0] reg_en,
   input logic [NUM_OUT-1:0] clk_out,
   input logic [NUM_OUT-1:0] running
);
   localparam int unsigned CW = $clog2(SYNC_STAGES + 2) + 1;

   // Gate state must only move while the reference clock is low.
   always @(running) begin
      if (rst_n === 1'b1) begin
         AST_GATE_LOW_PHASE: assert (ref_clk == 1'b0) else $error("gate moved with clock high"); // R8
      end
   end

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
      logic [CW-1:0] pin_lo_cnt, both_hi_cnt;
      logic          reg_lo_seen;

      always_ff @(negedge ref_clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_lo_cnt  <= '0;
            both_hi_cnt <= '0;
            reg_lo_seen <= 1'b0;
         end else begin
            pin_lo_cnt  <= !pin_en[g] ? ((pin_lo_cnt == CW'(SYNC_STAGES)) ? pin_lo_cnt : pin_lo_cnt + 1'b1) : '0;
            both_hi_cnt <= (pin_en[g] && reg_en[g]) ? ((both_hi_cnt == CW'(SYNC_STAGES)) ? both_hi_cnt : both_hi_cnt + 1'b1) : '0;
            reg_lo_seen <= !reg_en[g];
         end
      end

      AST_PIN_LOW_STOPS: assert property (@(negedge ref_clk) disable iff (!rst_n)
         (pin_lo_cnt == CW'(SYNC_STAGES) && !pin_en[g]) |=> !running[g]); // R2
      AST_REG_LOW_STOPS: assert property (@(negedge ref_clk) disable iff (!rst_n)
         (reg_lo_seen && !reg_en[g]) |=> !running[g]); // R2
      AST_BOTH_HIGH_RUNS: assert property (@(negedge ref_clk) disable iff (!rst_n)
         (both_hi_cnt == CW'(SYNC_STAGES) && pin_en[g] && reg_en[g]) |=> running[g]); // R1
      AST_PARKED_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
         !running[g] |=> !clk_out[g]); // R3
   end
endmodule

bind refclk_gate_bank refclk_gate_chk #(.NUM_OUT(NUM_OUT), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/refclk_gate_bank_tb_top.sv
`timescale 1ns/1ps
module refclk_gate_bank_tb_top;
   localparam int N = 4;

   logic         ref_clk = 1'b0;
   logic         rst_n   = 1'b0;
   logic [N-1:0] pin_en  = '0;
   logic [N-1:0] reg_en  = '0;
   logic [N-1:0] clk_out;
   logic [N-1:0] running;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   longint first_rise [N];
   longint last_rise  [N];
   longint last_fall  [N];
   int     rises      [N];
   int     bad_hi     [N];
   int     bad_gap    [N];

   always #2.5 ref_clk = ~ref_clk;

   refclk_gate_bank #(.NUM_OUT(N)) dut_i (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .pin_en  (pin_en),
      .reg_en  (reg_en),
      .clk_out (clk_out),
      .running (running)
   );

   function automatic longint now_ps();
      return longint'($rtoi($realtime * 1000.0 + 0.5));
   endfunction

   initial begin
      for (int i = 0; i < N; i++) begin
         first_rise[i] = -1; last_rise[i] = -1; last_fall[i] = -1;
         rises[i] = 0; bad_hi[i] = 0; bad_gap[i] = 0;
      end
   end

   // Pulse monitors: high phase must be 2500 ps, low gap 2500 + k*5000 ps (R4, R3, R7)
   for (genvar g = 0; g < N; g++) begin : g_mon
      always @(posedge clk_out[g]) begin
         longint t;
         t = now_ps();
         rises[g]++;
         last_rise[g] = t;
         if (first_rise[g] < 0) first_rise[g] = t;
         if (last_fall[g] >= 0 && ((t - last_fall[g] - 2500) % 5000) != 0) bad_gap[g]++;
      end
      always @(negedge clk_out[g]) begin
         longint t;
         t = now_ps();
         if (last_rise[g] >= 0 && (t - last_rise[g]) != 2500) bad_hi[g]++;
         last_fall[g] = t;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge ref_clk);
      #1;
   endtask

   task automatic clear_counts();
      for (int i = 0; i < N; i++) rises[i] = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      longint tp;
      // Reset state (R8)
      pin_en = '1; reg_en = '1;
      step(4);
      chk(running == '0, "R8 reset flags", running, 0);
      chk(clk_out == '0, "R8 reset outputs", clk_out, 0);
      rst_n = 1'b1;
      step(6);
      chk(running == '1, "R1 after reset", running, 15);

      // Exhaustive sweep of pin x register patterns (R1, R2)
      for (int p = 0; p < 16; p++) begin
         for (int r = 0; r < 16; r++) begin
            pin_en = 4'(p); reg_en = 4'(r);
            step(5);
            clear_counts();
            step(8);
            chk(running == 4'(p & r), "R1/R2 running flags", running, p & r);
            for (int i = 0; i < N; i++) begin
               chk(rises[i] == (((p & r) >> i) & 1 ? 8 : 0), "R1/R2 pulse count", rises[i], (((p & r) >> i) & 1) ? 8 : 0);
            end
         end
      end

      // Latency and independence per output
      pin_en = '1; reg_en = '1;
      step(6);
      for (int g = 0; g < N; g++) begin
         // pin stop (R5, R3, R7)
         @(posedge ref_clk); tp = now_ps(); #1;
         pin_en[g] = 1'b0;
         clear_counts();
         step(8);
         chk(last_rise[g] - tp == 10000, "R5 pin stop last rise", last_rise[g] - tp, 10000);
         chk(clk_out[g] == 1'b0 && running[g] == 1'b0, "R3 parked low", clk_out[g], 0);
         for (int i = 0; i < N; i++)
            if (i != g) chk(rises[i] == 8, "R7 neighbour undisturbed", rises[i], 8);
         // pin start (R5)
         @(posedge ref_clk); tp = now_ps(); #1;
         first_rise[g] = -1;
         pin_en[g] = 1'b1;
         step(8);
         chk(first_rise[g] - tp == 15000, "R5 pin start first rise", first_rise[g] - tp, 15000);
         chk((first_rise[g] - tp) >= 10000 && (first_rise[g] - tp) <= 30000, "R5 window", first_rise[g] - tp, 15000);
         // register stop (R6)
         @(posedge ref_clk); tp = now_ps(); #1;
         reg_en[g] = 1'b0;
         clear_counts();
         step(8);
         chk(last_rise[g] - tp == 5000, "R6 reg stop last rise", last_rise[g] - tp, 5000);
         chk(rises[g] == 1, "R3 no pulse after stop", rises[g], 1);
         // register start (R6, R7)
         @(posedge ref_clk); tp = now_ps(); #1;
         first_rise[g] = -1;
         reg_en[g] = 1'b1;
         clear_counts();
         step(8);
         chk(first_rise[g] - tp == 10000, "R6 reg start first rise", first_rise[g] - tp, 10000);
         for (int i = 0; i < N; i++)
            if (i != g) chk(rises[i] == 8, "R7 neighbour undisturbed", rises[i], 8);
      end

      // Pin toggled mid-phase, not aligned to clock (R4)
      for (int k = 0; k < 20; k++) begin
         #(1.3 + 0.7 * k);
         pin_en = 4'(k * 5);
         step(4);
      end
      step(10);

      for (int i = 0; i < N; i++) begin
         chk(bad_hi[i] == 0, "R4/R3 high width", bad_hi[i], 0);
         chk(bad_gap[i] == 0, "R4 low gap", bad_gap[i], 0);
      end
      finish_run();
   end
endmodule